// File: doc/BRIEF.md
# SIMD Saturating Left Shift by Immediate

This unit shifts every active element of a 128-bit SIMD operand left by an immediate amount and clamps the result whenever the shifted value no longer fits. A single packed 7-bit immediate carries two facts. The position of its highest set bit in the upper four bits sets the element width. The rest of the immediate gives the shift amount. Three clamping rules are available: signed source to signed result, signed source to unsigned result, and unsigned source to unsigned result.

An execution pipeline drives one request per valid strobe. The request carries the operand, the split immediate, the unsigned-select bit, the full-width (128-bit vector) bit, a scalar select and the 5-bit opcode. One cycle later the unit returns one of two things: a registered result with a result-valid strobe, or an undefined-encoding strobe. A sticky flag records that some active element clamped. The flag stays set until software-side logic pulses the clear input. In vector form a 64-bit request uses only the low half of the operand. In scalar form only the lowest element is used. In both cases the destination bits that are not used come back as zero.

Top module: `simd_qshl_imm`

## Requirements
- R1: The element width is 8, 16, 32 or 64 bits when the highest set bit of `imm_hi` is bit 0, 1, 2 or 3. The shift amount is `{imm_hi, imm_lo}` minus the element width, which gives 0 to width-1.
- R2: Opcode 0x0E with `unsigned_sel`=0 treats elements as signed. A shifted value above the signed maximum gives the signed maximum, and one below the signed minimum gives the signed minimum. Otherwise the low element bits of the shifted value are returned.
- R3: Opcode 0x0C with `unsigned_sel`=1 treats the source as signed and the result as unsigned. A negative element gives 0 and counts as a clamp. A shifted value above the unsigned maximum gives all ones.
- R4: Opcode 0x0E with `unsigned_sel`=1 treats elements as unsigned. Any set bit shifted beyond the element width gives all ones.
- R5: Opcode 0x0C with `unsigned_sel`=0 is undefined, and so is any opcode other than 0x0C and 0x0E.
- R6: `imm_hi`=0 is undefined. In vector form (`scalar_sel`=0), `full_width`=0 together with `imm_hi[3]`=1 is undefined.
- R7: An undefined request raises `res_undef` for one cycle and leaves `res_valid` low. It also leaves `res_data` and `sat_sticky` unchanged, except that a clear given in the same cycle still applies.
- R8: In vector form with `full_width`=1, all 128/width elements are processed. With `full_width`=0, only the 64/width elements in bits 63:0 are processed, and `res_data[127:64]` is zero.
- R9: In scalar form only the element in bits width-1:0 is processed. Every higher result bit is zero.
- R10: `res_valid` or `res_undef` is asserted exactly one cycle after the cycle in which `req_valid` was sampled high. `res_data` changes only in a cycle where `res_valid` is high.
- R11: `sat_sticky` goes high one cycle after a legal request in which any active element clamps. Elements that are not active never set it. It stays high until `sat_clear` is sampled. If a clear and a clamping request arrive in the same cycle, the flag ends up set.
- R12: While `rst_n` is low at a clock edge, all outputs go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| src_data | input | 128 | Source operand |
| imm_hi | input | 4 | Upper immediate bits (width select) |
| imm_lo | input | 3 | Lower immediate bits |
| unsigned_sel | input | 1 | Unsigned-select bit |
| full_width | input | 1 | Vector is 128 bits when 1, 64 bits when 0 |
| scalar_sel | input | 1 | Scalar form when 1 |
| op_code | input | 5 | Operation code (0x0C or 0x0E) |
| sat_clear | input | 1 | Clears the sticky saturation flag |
| res_data | output | 128 | Registered result |
| res_valid | output | 1 | Result strobe |
| res_undef | output | 1 | Undefined-encoding strobe |
| sat_sticky | output | 1 | Sticky saturation flag |

## Verification
Every result, undefined strobe and update of the sticky flag appears at the first rising edge after the request is sampled, since there is only one register stage. The driver computes the expected output when it presents a request and puts it in a queue. The monitor looks 2 ns after every rising edge and takes one entry from the queue for each strobe it sees. A strobe that is missing or comes at the wrong time therefore shows up as a leftover or an unexpected entry. Clearing the flag on its own is checked at the falling edge after the clear cycle.

// File: rtl/qshl_pkg.sv
// Shared types and constants for the saturating immediate shifter.
// Assumes a 4-bit width-select field and a 3-bit low immediate field.
package qshl_pkg;
    localparam int IMMH_W  = 4;
    localparam int IMMB_W  = 3;
    localparam int IMM_W   = IMMH_W + IMMB_W;
    localparam int SHAMT_W = 6;
    localparam int SIZE_W  = 2;
    localparam int NSIZE   = 4;
    localparam int OPC_W   = 5;

    localparam logic [OPC_W-1:0] OPC_SAT_SAME = 5'h0E;
    localparam logic [OPC_W-1:0] OPC_SAT_S2U  = 5'h0C;

    typedef enum logic [1:0] {
        QM_S2S = 2'd0,
        QM_S2U = 2'd1,
        QM_U2U = 2'd2
    } qmode_t;

    typedef struct packed {
        logic               undef;
        logic [SIZE_W-1:0]  size;
        logic [SHAMT_W-1:0] shamt;
        qmode_t             mode;
    } qdec_t;
endpackage

// File: rtl/qshl_decode.sv
// Decoder: turns the packed immediate, opcode and form bits into an
// element size, a shift amount, a clamping mode and an undefined flag.
// Assumes the caller has already selected the saturating-shift opcode group.
module qshl_decode
    import qshl_pkg::*;
(
    input  logic [IMMH_W-1:0] imm_hi,
    input  logic [IMMB_W-1:0] imm_lo,
    input  logic              unsigned_sel,
    input  logic              full_width,
    input  logic              scalar_sel,
    input  logic [OPC_W-1:0]  op_code,
    output qdec_t             dec
);
    logic [IMM_W-1:0] imm_all;
    logic [IMM_W-1:0] esize;
    logic [IMM_W-1:0] diff;
    logic             bad_op;

    assign imm_all = {imm_hi, imm_lo};

    // Pick the size from the top set bit, then derive shift, mode and legality.
    always_comb begin
        dec = '0;
        casez (imm_hi)
            4'b1???: dec.size = 2'd3;
            4'b01??: dec.size = 2'd2;
            4'b001?: dec.size = 2'd1;
            default: dec.size = 2'd0;
        endcase
        esize     = IMM_W'(8) << dec.size;
        diff      = imm_all - esize;
        dec.shamt = diff[SHAMT_W-1:0];
        bad_op    = 1'b0;
        if (op_code == OPC_SAT_SAME) begin
            dec.mode = unsigned_sel ? QM_U2U : QM_S2S;
        end else if (op_code == OPC_SAT_S2U) begin
            dec.mode = QM_S2U;
            bad_op   = !unsigned_sel;
        end else begin
            dec.mode = QM_S2S;
            bad_op   = 1'b1;
        end
        dec.undef = (imm_hi == '0) || bad_op ||
                    (!scalar_sel && !full_width && imm_hi[IMMH_W-1]);
    end
endmodule

// File: rtl/qshl_lane.sv
// One element lane: shifts left and clamps according to the mode.
// Overflow is found by shifting back and comparing with the input.
// Assumes shamt < ELEM_W whenever this lane's width is the selected one.
module qshl_lane
    import qshl_pkg::*;
#(
    parameter int ELEM_W = 8
) (
    input  logic [ELEM_W-1:0]  x,
    input  logic [SHAMT_W-1:0] shamt,
    input  qmode_t             mode,
    output logic [ELEM_W-1:0]  y,
    output logic               sat
);
    localparam logic [ELEM_W-1:0] SMAX = {1'b0, {(ELEM_W-1){1'b1}}};
    localparam logic [ELEM_W-1:0] SMIN = {1'b1, {(ELEM_W-1){1'b0}}};

    logic [ELEM_W-1:0] shl;
    logic [ELEM_W-1:0] back_u;
    logic [ELEM_W-1:0] back_s;

    // Raw shift and the two shift-back forms used to detect lost bits.
    always_comb begin
        shl    = x << shamt;
        back_u = shl >> shamt;
        back_s = $signed(shl) >>> shamt;
    end

    // Apply the clamping rule of the selected mode.
    always_comb begin
        y   = shl;
        sat = 1'b0;
        unique case (mode)
            QM_S2S: begin
                if (back_s != x) begin
                    sat = 1'b1;
                    y   = x[ELEM_W-1] ? SMIN : SMAX;
                end
            end
            QM_S2U: begin
                if (x[ELEM_W-1]) begin
                    sat = 1'b1;
                    y   = '0;
                end else if (back_u != x) begin
                    sat = 1'b1;
                    y   = '1;
                end
            end
            default: begin
                if (back_u != x) begin
                    sat = 1'b1;
                    y   = '1;
                end
            end
        endcase
    end
endmodule

// File: rtl/qshl_bank.sv
// Bank of lanes for one element width across the whole operand.
// Masks lanes outside the active range (scalar or 64-bit vector) to zero
// and reports whether any active lane clamped. Assumes DATA_W % ELEM_W == 0.
module qshl_bank
    import qshl_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int ELEM_W = 8
) (
    input  logic [DATA_W-1:0]  src_data,
    input  logic [SHAMT_W-1:0] shamt,
    input  qmode_t             mode,
    input  logic               scalar_sel,
    input  logic               full_width,
    output logic [DATA_W-1:0]  y,
    output logic               sat_any
);
    localparam int NLANE = DATA_W / ELEM_W;
    localparam int HALF  = DATA_W / 2;

    logic [NLANE-1:0] lane_sat;
    logic [NLANE-1:0] lane_act;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int BASE = g * ELEM_W;
        localparam bit LOWER = (BASE < HALF);
        localparam bit FIRST = (g == 0);
        logic [ELEM_W-1:0] raw;

        qshl_lane #(.ELEM_W(ELEM_W)) u_lane (
            .x     (src_data[BASE +: ELEM_W]),
            .shamt (shamt),
            .mode  (mode),
            .y     (raw),
            .sat   (lane_sat[g])
        );

        // Decide whether this lane takes part in the current form.
        assign lane_act[g] = scalar_sel ? FIRST : (full_width ? 1'b1 : LOWER);
        // Zero-fill the destination bits of inactive lanes.
        assign y[BASE +: ELEM_W] = lane_act[g] ? raw : '0;
    end

    // Only active lanes contribute to saturation.
    assign sat_any = |(lane_sat & lane_act);
endmodule

// File: rtl/simd_qshl_imm.sv
// Top: saturating left shift by immediate on a SIMD operand.
// Decodes the request, runs one lane bank per element width in parallel,
// selects the decoded width and registers result, strobes and sticky flag.
// Assumes DATA_W >= 128 so every width has at least two lanes.
module simd_qshl_imm
    import qshl_pkg::*;
#(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] src_data,
    input  logic [3:0]        imm_hi,
    input  logic [2:0]        imm_lo,
    input  logic              unsigned_sel,
    input  logic              full_width,
    input  logic              scalar_sel,
    input  logic [4:0]        op_code,
    input  logic              sat_clear,
    output logic [DATA_W-1:0] res_data,
    output logic              res_valid,
    output logic              res_undef,
    output logic              sat_sticky
);
    qdec_t                         dec;
    logic [NSIZE-1:0][DATA_W-1:0]  bank_y;
    logic [NSIZE-1:0]              bank_sat;
    logic [DATA_W-1:0]             sel_y;
    logic                          sel_sat;
    logic                          legal;

    qshl_decode u_dec (
        .imm_hi       (imm_hi),
        .imm_lo       (imm_lo),
        .unsigned_sel (unsigned_sel),
        .full_width   (full_width),
        .scalar_sel   (scalar_sel),
        .op_code      (op_code),
        .dec          (dec)
    );

    for (genvar k = 0; k < NSIZE; k++) begin : g_bank
        qshl_bank #(.DATA_W(DATA_W), .ELEM_W(8 << k)) u_bank (
            .src_data   (src_data),
            .shamt      (dec.shamt),
            .mode       (dec.mode),
            .scalar_sel (scalar_sel),
            .full_width (full_width),
            .y          (bank_y[k]),
            .sat_any    (bank_sat[k])
        );
    end

    // Select the bank matching the decoded element width.
    always_comb begin
        sel_y   = bank_y[dec.size];
        sel_sat = bank_sat[dec.size];
        legal   = req_valid && !dec.undef;
    end

    // Register the strobes: one cycle from request to answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_undef <= 1'b0;
        end else begin
            res_valid <= legal;
            res_undef <= req_valid && dec.undef;
        end
    end

    // Capture the result only for legal requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_data <= '0;
        end else if (legal) begin
            res_data <= sel_y;
        end
    end

    // Sticky saturation: a new clamp wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sat_sticky <= 1'b0;
        end else begin
            sat_sticky <= (sat_sticky && !sat_clear) || (legal && sel_sat);
        end
    end
endmodule

// File: rtl/qshl_chk.sv
// Checker for simd_qshl_imm: timing of strobes, undefined encodings,
// zero-fill of unused bits and sticky flag behaviour. Attached by bind.
module qshl_chk #(
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [DATA_W-1:0] src_data,
    input logic [3:0]        imm_hi,
    input logic [2:0]        imm_lo,
    input logic              unsigned_sel,
    input logic              full_width,
    input logic              scalar_sel,
    input logic [4:0]        op_code,
    input logic              sat_clear,
    input logic [DATA_W-1:0] res_data,
    input logic              res_valid,
    input logic              res_undef,
    input logic              sat_sticky
);
    localparam int HALF = DATA_W / 2;

    p_strobe_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid || res_undef) |-> $past(req_valid));

    p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(res_data));

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && res_undef));

    p_s2u_needs_u_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_code == 5'h0C && !unsigned_sel) |=> (res_undef && !res_valid));

    p_zero_immh_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && imm_hi == 4'd0) |=> res_undef);

    p_half_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !scalar_sel && !full_width) |=>
        (res_undef || res_data[DATA_W-1:HALF] == '0));

    p_scalar_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && scalar_sel && imm_hi == 4'b0001) |=>
        (res_undef || res_data[DATA_W-1:8] == '0));

    p_sticky_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_sticky && !sat_clear) |=> sat_sticky);
endmodule

bind simd_qshl_imm qshl_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_simd_qshl_imm.sv
// Scoreboard bench: the driver queues expected answers, the monitor
// compares them against the strobes one cycle later.
module tb_simd_qshl_imm;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [127:0] src_data = '0;
    logic [3:0]   imm_hi = '0;
    logic [2:0]   imm_lo = '0;
    logic         unsigned_sel = 1'b0;
    logic         full_width = 1'b0;
    logic         scalar_sel = 1'b0;
    logic [4:0]   op_code = '0;
    logic         sat_clear = 1'b0;
    logic [127:0] res_data;
    logic         res_valid;
    logic         res_undef;
    logic         sat_sticky;

    int n_chk = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;

    typedef struct {
        logic         v;
        logic         ud;
        logic [127:0] d;
        logic         s;
        string        tag;
    } exp_t;
    exp_t sb[$];

    logic [127:0] m_res = '0;
    logic         m_sat = 1'b0;

    simd_qshl_imm dut (.*);

    always #5 clk = ~clk;

    // Reference model for one element, using wide range comparisons.
    function automatic logic [63:0] ref_lane(input logic [63:0] x, input int w,
                                             input int sh, input int mode,
                                             output logic sat);
        logic signed [129:0] uv, sv, p, pu, maxs, mins, maxu, r;
        logic [63:0] mask;
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        uv   = $signed({66'd0, x & mask});
        sv   = x[w-1] ? uv - (130'sd1 <<< w) : uv;
        p    = sv <<< sh;
        pu   = uv <<< sh;
        maxs = (130'sd1 <<< (w - 1)) - 130'sd1;
        mins = -(130'sd1 <<< (w - 1));
        maxu = (130'sd1 <<< w) - 130'sd1;
        sat  = 1'b0;
        r    = p;
        if (mode == 0) begin
            if (p > maxs) begin sat = 1'b1; r = maxs; end
            else if (p < mins) begin sat = 1'b1; r = mins; end
        end else if (mode == 1) begin
            if (sv < 0) begin sat = 1'b1; r = '0; end
            else if (p > maxu) begin sat = 1'b1; r = maxu; end
        end else begin
            r = pu;
            if (pu > maxu) begin sat = 1'b1; r = maxu; end
        end
        return r[63:0] & mask;
    endfunction

    // Driver: present one request for a cycle and queue its expected answer.
    task automatic do_op(input logic [127:0] src, input logic [3:0] ih,
                         input logic [2:0] ib, input logic u, input logic q,
                         input logic sc, input logic [4:0] opc,
                         input logic clr, input string tag);
        logic und, nsat, ls;
        int w, sh, nl, mode, k;
        logic [127:0] nres, lmask;
        exp_t e;
        und = (ih == 4'd0) || !(opc == 5'h0E || (opc == 5'h0C && u)) ||
              (!sc && !q && ih[3]);
        mode = (opc == 5'h0E) ? (u ? 2 : 0) : 1;
        k = 0;
        for (int b = 3; b >= 0; b--) if (ih[b] && k == 0) k = b + 1;
        w = (k == 0) ? 8 : (8 << (k - 1));
        sh = int'({ih, ib}) - w;
        nl = sc ? 1 : ((q ? 128 : 64) / w);
        nres = '0;
        nsat = 1'b0;
        lmask = (w == 64) ? 128'h0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFF
                          : ((128'd1 << w) - 128'd1);
        if (!und) begin
            for (int i = 0; i < nl; i++) begin
                logic [63:0] y;
                y = ref_lane(64'((src >> (i * w)) & lmask), w, sh, mode, ls);
                nres |= (128'(y) & lmask) << (i * w);
                nsat |= ls;
            end
            m_res = nres;
        end
        m_sat = (m_sat && !clr) || (!und && nsat);
        e.v = !und; e.ud = und; e.d = m_res; e.s = m_sat; e.tag = tag;
        @(negedge clk);
        src_data = src; imm_hi = ih; imm_lo = ib; unsigned_sel = u;
        full_width = q; scalar_sel = sc; op_code = opc; sat_clear = clr;
        req_valid = 1'b1;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        sat_clear = 1'b0;
    endtask

    // Clear-only cycle, then check the flag is low (R11).
    task automatic do_clear();
        @(negedge clk);
        sat_clear = 1'b1;
        m_sat = 1'b0;
        @(negedge clk);
        sat_clear = 1'b0;
        n_chk++;
        if (sat_sticky !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 clear: actual sat=%b expected 0", sat_sticky);
        end
    endtask

    // Monitor: 2 ns after each rising edge, match strobes against the queue.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (mon_on && (res_valid || res_undef)) begin
                n_chk++;
                if (sb.size() == 0) begin
                    n_fail++;
                    $display("FAIL R10 unexpected strobe: actual v=%b u=%b expected none",
                             res_valid, res_undef);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (res_valid !== e.v || res_undef !== e.ud ||
                        res_data !== e.d || sat_sticky !== e.s) begin
                        n_fail++;
                        $display("FAIL %s: actual v=%b u=%b d=%h s=%b expected v=%b u=%b d=%h s=%b",
                                 e.tag, res_valid, res_undef, res_data, sat_sticky,
                                 e.v, e.ud, e.d, e.s);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL R10 watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Stimulus sequence.
    initial begin
        logic [127:0] rnd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: outputs after reset
        n_chk++;
        if (res_data !== '0 || res_valid !== 1'b0 || res_undef !== 1'b0 || sat_sticky !== 1'b0) begin
            n_fail++;
            $display("FAIL R12 reset: actual d=%h v=%b u=%b s=%b expected all zero",
                     res_data, res_valid, res_undef, sat_sticky);
        end
        mon_on = 1'b1;

        // R2: signed bytes, shift 1, clamps both ways
        do_op(128'h0102_0304_7F80_C0BF_4081_C001_3FE0_1020, 4'b0001, 3'b001, 0, 1, 0, 5'h0E, 0, "R2 s2s byte");
        do_clear();
        // R2: no clamp case leaves flag low
        do_op(128'h0001_FFFF_0010_FFF0_0002_FFFE_0003_1FFF, 4'b0010, 3'b010, 0, 1, 0, 5'h0E, 0, "R2 s2s half");
        // R3: signed to unsigned halves, shift 4
        do_op(128'h0FFF_F000_0800_0001_8000_07FF_1000_0000, 4'b0010, 3'b100, 1, 1, 0, 5'h0C, 0, "R3 s2u half");
        do_clear();
        // R4 + R1: unsigned words with lower immh bits set, shift 31
        do_op(128'h0000_0001_0000_0000_0000_0002_8000_0000, 4'b0111, 3'b111, 1, 1, 0, 5'h0E, 0, "R4 u2u word");
        // R1: 64-bit elements, shift 0 and shift 63
        do_op(128'hFFFF_0000_1234_5678_8000_0000_0000_0001, 4'b1000, 3'b000, 0, 1, 0, 5'h0E, 0, "R1 d shift0");
        do_op(128'h0000_0000_0000_0001_FFFF_FFFF_FFFF_FFFF, 4'b1111, 3'b111, 0, 1, 0, 5'h0E, 0, "R1 d shift63");
        do_clear();
        // R8 + R11: 64-bit vector, upper half would clamp but is inactive
        do_op(128'hFFFF_FFFF_FFFF_FFFF_0101_0101_0000_0001, 4'b0001, 3'b110, 1, 0, 0, 5'h0E, 0, "R8 half vector");
        // R9 + R11: scalar byte, lane 1 would clamp but is ignored
        do_op(128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FF03, 4'b0001, 3'b010, 1, 0, 1, 5'h0E, 0, "R9 scalar byte");
        // R9: scalar word, s2s clamp
        do_op(128'h1111_2222_3333_4444_5555_6666_4000_0000, 4'b0100, 3'b001, 0, 0, 1, 5'h0E, 0, "R9 scalar word");
        // R11: clear together with a clamp leaves the flag set
        do_op(128'h0000_0000_0000_0000_0000_0000_0000_00FF, 4'b0001, 3'b111, 1, 1, 1, 5'h0E, 1, "R11 set beats clear");
        // R5 / R7: s2u opcode without unsigned bit
        do_op(128'h0, 4'b0001, 3'b000, 0, 1, 0, 5'h0C, 0, "R5 s2u with u=0");
        // R5: other opcode
        do_op(128'h5, 4'b0010, 3'b000, 1, 1, 0, 5'h05, 0, "R5 other opcode");
        // R6 / R7: immh zero, with a clear in the same cycle
        do_op(128'h7, 4'b0000, 3'b101, 1, 1, 0, 5'h0E, 1, "R6 immh zero");
        // R6: 64-bit element in 64-bit vector
        do_op(128'h9, 4'b1010, 3'b000, 0, 0, 0, 5'h0E, 0, "R6 d in half vector");

        // Sweep every immediate across modes and forms (R1-covering sweep)
        for (int ih = 1; ih < 16; ih++) begin
            for (int ib = 0; ib < 8; ib++) begin
                for (int cfg = 0; cfg < 6; cfg++) begin
                    rnd = {$urandom, $urandom, $urandom, $urandom};
                    if (cfg[0]) rnd = rnd & {16{8'h0F}};
                    do_op(rnd, 4'(ih), 3'(ib), cfg >= 2, cfg[1] ^ cfg[0], cfg == 5,
                          (cfg == 2 || cfg == 3) ? 5'h0C : 5'h0E, 0, "R1 sweep");
                end
            end
        end

        repeat (4) @(negedge clk);
        n_chk++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R10 missing strobes: actual %0d pending expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule